// File: doc/BRIEF.md
# Memory-to-memory block copy engine

This block is a single-channel copy engine placed between a CPU register bus and a word-wide memory port. Software programs a source address, a target address and a byte count through a small register window at a fixed base address. It then writes 1 to the control register. The engine copies the block one 32-bit word at a time. For each word it reads the source location and then writes the same value to the target location.

When the last word has been written, the engine raises a level interrupt and holds it. The control register serves both to start a copy and to acknowledge its completion. Writing 0 to it after completion drops the interrupt and returns the engine to idle. While a copy runs, the three address and size registers stay readable and writable, because the engine works from its own latched copies of them.

Top module: `dma_copy_engine`

## Requirements
- R1: Reset is synchronous and active low (`rst_n` = 0 at a clock edge). It clears the source, target and size registers and the control bit to 0, drives `irq` low and leaves `m_req` low.
- R2: Register offsets from `BASE_ADDR` are: source at 0x0, target at 0x4, size at 0x8 and control at 0xC (bit 0). Each register reads back through the slave port, with `s_rvalid` and `s_rdata` valid one cycle after the read is accepted. Writes outside the 16-byte window change nothing, and reads there return 0.
- R3: Writing 1 to control bit 0 while idle starts a copy. Control reads back as 1 from then until the completion is cleared.
- R4: A copy moves ceil(SIZE/4) words, where SIZE is in bytes. Word i is read from SOURCE+4i and written to TARGET+4i. Target words beyond that count are untouched.
- R5: Each word is one master read (`m_we`=0) followed by one master write (`m_we`=1) of the data just read. Only one request is outstanding, and `m_req`, `m_we` and `m_addr` hold steady until `m_ack`.
- R6: A SIZE of 0 issues no master request. In that case `irq` is high in the cycle after the start write.
- R7: On completion `irq` goes high and stays high until control is written with 0. It is low in the cycle after that write, and control then reads 0.
- R8: Writing 1 to control while a copy is busy or waiting for its clear is ignored. The copy completes with the original word count.
- R9: Writing 0 to control while idle has no effect: `irq` and `m_req` stay low and control reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Register access request |
| s_ready | output | 1 | Register access accepted (always 1) |
| s_write | input | 1 | 1 = write, 0 = read |
| s_addr | input | 32 | Register byte address |
| s_wdata | input | 32 | Register write data |
| s_rdata | output | 32 | Register read data |
| s_rvalid | output | 1 | Read data valid, one cycle after the read |
| m_req | output | 1 | Memory request |
| m_we | output | 1 | Memory request is a write |
| m_addr | output | 32 | Memory byte address |
| m_wdata | output | 32 | Memory write data |
| m_ack | input | 1 | Memory request completed |
| m_rdata | input | 32 | Memory read data, valid with `m_ack` |
| irq | output | 1 | Completion interrupt (level) |

## Verification
The hardest state to reach from the ports is a second start write landing while the engine is mid-copy or waiting for its clear. The bench issues a repeat start directly after the first one, while the memory model is still answering reads. It then confirms that the number of target writes and the copied contents match the original size. A reset asserted in the middle of a copy also requires careful timing. The bench fires it after a few memory handshakes and then checks that every register is cleared and that the master port is quiet. Sizes are swept across every residue modulo 4, so that the rounding up of a partial last word is exercised.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } dma_state_e;

    localparam logic [3:0] OFS_SRC  = 4'h0;
    localparam logic [3:0] OFS_DST  = 4'h4;
    localparam logic [3:0] OFS_SIZE = 4'h8;
    localparam logic [3:0] OFS_CTL  = 4'hC;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] size;
    } dma_cfg_t;

    // word count for a byte count, rounding a partial word up
    function automatic logic [31:0] words_for(input logic [31:0] bytes);
        return {2'b00, bytes[31:2]} + {31'd0, |bytes[1:0]};
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h4000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        s_valid,
    input  logic        s_write,
    input  logic [31:0] s_addr,
    input  logic [31:0] s_wdata,
    input  logic        active,
    output logic [31:0] s_rdata,
    output logic        s_rvalid,
    output dma_cfg_t    cfg,
    output logic        ctl_wr,
    output logic        ctl_val
);
    localparam int WIN_LSB = 4;

    logic       hit;
    logic [3:0] ofs;
    logic [31:0] rd_mux;

    assign hit     = (s_addr[31:WIN_LSB] == BASE_ADDR[31:WIN_LSB]);
    assign ofs     = s_addr[WIN_LSB-1:0];
    assign ctl_wr  = s_valid && s_write && hit && (ofs == OFS_CTL);
    assign ctl_val = s_wdata[0];

    always_comb begin
        rd_mux = '0;
        if (hit) begin
            case (ofs)
                OFS_SRC:  rd_mux = cfg.src;
                OFS_DST:  rd_mux = cfg.dst;
                OFS_SIZE: rd_mux = cfg.size;
                OFS_CTL:  rd_mux = {31'd0, active};
                default:  rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '0;
            s_rdata  <= '0;
            s_rvalid <= 1'b0;
        end else begin
            s_rvalid <= s_valid && !s_write;
            if (s_valid && !s_write) s_rdata <= rd_mux;
            if (s_valid && s_write && hit) begin
                case (ofs)
                    OFS_SRC:  cfg.src  <= s_wdata;
                    OFS_DST:  cfg.dst  <= s_wdata;
                    OFS_SIZE: cfg.size <= s_wdata;
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dma_mover.sv
module dma_mover
    import dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  dma_cfg_t    cfg,
    input  logic        ctl_wr,
    input  logic        ctl_val,
    output logic        active,
    output logic        irq,
    output logic        m_req,
    output logic        m_we,
    output logic [31:0] m_addr,
    output logic [31:0] m_wdata,
    input  logic        m_ack,
    input  logic [31:0] m_rdata
);
    localparam logic [31:0] STEP = 32'd4;

    dma_state_e  state;
    logic        wr_phase;
    logic [31:0] cur_src, cur_dst, left, hold;

    assign active  = (state != ST_IDLE);
    assign irq     = (state == ST_DONE);
    assign m_req   = (state == ST_BUSY);
    assign m_we    = wr_phase;
    assign m_addr  = wr_phase ? cur_dst : cur_src;
    assign m_wdata = hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wr_phase <= 1'b0;
            cur_src  <= '0;
            cur_dst  <= '0;
            left     <= '0;
            hold     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    wr_phase <= 1'b0;
                    if (ctl_wr && ctl_val) begin
                        cur_src <= cfg.src;
                        cur_dst <= cfg.dst;
                        left    <= words_for(cfg.size);
                        state   <= (words_for(cfg.size) == 0) ? ST_DONE : ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (m_ack) begin
                        if (!wr_phase) begin
                            hold     <= m_rdata;
                            wr_phase <= 1'b1;
                        end else begin
                            wr_phase <= 1'b0;
                            cur_src  <= cur_src + STEP;
                            cur_dst  <= cur_dst + STEP;
                            left     <= left - 1'b1;
                            if (left == 32'd1) state <= ST_DONE;
                        end
                    end
                end
                ST_DONE: begin
                    if (ctl_wr && !ctl_val) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
    import dma_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h4000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        s_valid,
    output logic        s_ready,
    input  logic        s_write,
    input  logic [31:0] s_addr,
    input  logic [31:0] s_wdata,
    output logic [31:0] s_rdata,
    output logic        s_rvalid,
    output logic        m_req,
    output logic        m_we,
    output logic [31:0] m_addr,
    output logic [31:0] m_wdata,
    input  logic        m_ack,
    input  logic [31:0] m_rdata,
    output logic        irq
);
    dma_cfg_t cfg;
    logic     ctl_wr, ctl_val, active;

    assign s_ready = 1'b1;

    dma_regs #(.BASE_ADDR(BASE_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_write(s_write),
        .s_addr(s_addr), .s_wdata(s_wdata), .active(active),
        .s_rdata(s_rdata), .s_rvalid(s_rvalid), .cfg(cfg),
        .ctl_wr(ctl_wr), .ctl_val(ctl_val)
    );

    dma_mover u_mover (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .ctl_wr(ctl_wr), .ctl_val(ctl_val),
        .active(active), .irq(irq), .m_req(m_req), .m_we(m_we),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata)
    );
endmodule

// File: rtl/dma_copy_chk.sv
module dma_copy_chk #(
    parameter logic [31:0] BASE_ADDR = 32'h4000_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        s_valid,
    input logic        s_write,
    input logic [31:0] s_addr,
    input logic [31:0] s_wdata,
    input logic        m_req,
    input logic        m_we,
    input logic [31:0] m_addr,
    input logic [31:0] m_wdata,
    input logic        m_ack,
    input logic [31:0] m_rdata,
    input logic        irq
);
    logic        clr_wr;
    logic [31:0] last_rd;

    assign clr_wr = s_valid && s_write && (s_addr == BASE_ADDR + 32'hC) && !s_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) last_rd <= '0;
        else if (m_req && !m_we && m_ack) last_rd <= m_rdata;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !irq && !m_req);
    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_req && !m_ack |=> m_req && $stable(m_we) && $stable(m_addr));
    // R5
    wr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_req && m_we |-> m_wdata == last_rd);
    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr_wr |=> irq);
    // R7
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && clr_wr |=> !irq);
    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !m_req);
endmodule

bind dma_copy_engine dma_copy_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (.*);

// File: tb/tb_dma_copy_engine.sv
module tb_dma_copy_engine;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam logic [31:0] SRC  = 32'h0000_0100;
    localparam logic [31:0] DST  = 32'h0000_0200;

    logic clk = 0, rst_n = 0;
    logic s_valid = 0, s_write = 0, s_ready, s_rvalid;
    logic [31:0] s_addr = 0, s_wdata = 0, s_rdata;
    logic m_req, m_we, m_ack = 0, irq;
    logic [31:0] m_addr, m_wdata, m_rdata = 0;
    logic [31:0] mem [256];
    int checks = 0, errors = 0, wr_count = 0, cycles = 0, hs = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_copy_engine #(.BASE_ADDR(BASE)) dut (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (m_req && !m_ack) begin
            m_ack <= 1'b1;
            hs    <= hs + 1;
            if (m_we) begin
                mem[m_addr[9:2]] <= m_wdata;
                wr_count <= wr_count + 1;
            end else m_rdata <= mem[m_addr[9:2]];
        end else m_ack <= 1'b0;
    end

    initial begin
        while (cycles < 100000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        s_valid = 1; s_write = 1; s_addr = a; s_wdata = d;
        @(negedge clk);
        s_valid = 0; s_write = 0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        s_valid = 1; s_write = 0; s_addr = a;
        @(negedge clk);
        s_valid = 0;
        d = s_rvalid ? s_rdata : 32'hBAD0_BAD0;
    endtask

    function automatic logic [31:0] pat(input int sz, input int i);
        return 32'hA500_0000 ^ (sz << 12) ^ (i * 32'h0101);
    endfunction

    task automatic wait_irq();
        for (int k = 0; k < 400 && !irq; k++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int nw;
        int sizes [16] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,17,40};
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 m_req", {31'd0, m_req}, 0);
        rst_n = 1;
        for (int r = 0; r < 4; r++) begin
            rd(BASE + r*4, v);
            check("R1 reg cleared", v, 0);
        end
        // R2 readback and window
        wr(BASE + 0, 32'h1234_5678); wr(BASE + 4, 32'h9ABC_DEF0); wr(BASE + 8, 32'h0F0F_0F0F);
        wr(BASE + 32'h10, 32'hFFFF_FFFF); wr(BASE - 4, 32'hFFFF_FFFF);
        rd(BASE + 0, v); check("R2 source", v, 32'h1234_5678);
        rd(BASE + 4, v); check("R2 target", v, 32'h9ABC_DEF0);
        rd(BASE + 8, v); check("R2 size", v, 32'h0F0F_0F0F);
        rd(BASE + 32'h10, v); check("R2 outside read", v, 0);
        // R9 clear while idle
        wr(BASE + 12, 0);
        check("R9 irq", {31'd0, irq}, 0);
        check("R9 m_req", {31'd0, m_req}, 0);
        rd(BASE + 12, v); check("R9 ctl", v, 0);

        foreach (sizes[j]) begin
            nw = (sizes[j] + 3) / 4;
            for (int i = 0; i < 64; i++) begin
                mem[64 + i]  = pat(sizes[j], i);
                mem[128 + i] = 32'hDEAD_0000 + i;
            end
            wr_count = 0;
            wr(BASE + 0, SRC); wr(BASE + 4, DST); wr(BASE + 8, sizes[j]);
            wr(BASE + 12, 1);
            if (sizes[j] == 0) begin
                check("R6 irq next cycle", {31'd0, irq}, 1);
            end else begin
                check("R3 started", {31'd0, m_req}, 1);
                // R8 repeat start while busy
                if (j % 2 == 1) wr(BASE + 12, 1);
            end
            wait_irq();
            check("R7 irq on completion", {31'd0, irq}, 1);
            // R8 repeat start while waiting clear
            wr(BASE + 12, 1);
            check("R8 irq stays", {31'd0, irq}, 1);
            rd(BASE + 12, v); check("R3 ctl busy", v, 1);
            check("R4 word count", wr_count, nw);
            for (int i = 0; i < nw; i++) check("R4 data", mem[128 + i], pat(sizes[j], i));
            check("R4 untouched", mem[128 + nw], 32'hDEAD_0000 + nw);
            repeat (3) @(negedge clk);
            check("R7 irq held", {31'd0, irq}, 1);
            wr(BASE + 12, 0);
            check("R7 irq cleared", {31'd0, irq}, 0);
            rd(BASE + 12, v); check("R7 ctl cleared", v, 0);
        end

        // R1 reset mid-copy
        wr(BASE + 8, 32'd64);
        hs = 0;
        wr(BASE + 12, 1);
        while (hs < 5) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check("R1 mid irq", {31'd0, irq}, 0);
        check("R1 mid m_req", {31'd0, m_req}, 0);
        for (int r = 0; r < 4; r++) begin
            rd(BASE + r*4, v);
            check("R1 mid reg", v, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule